// File: doc/BRIEF.md
# Differential Lane Serializer (Transmit)

This block turns a parallel word produced by core logic into a serial bit stream for one differential output lane. The core presents a word and an output-enable flag on a slow parallel clock. A fast serial clock, phase-locked to the parallel clock, then moves the word to the lane pin one bit at a time, most significant bit first. The number of bits per word (the factor) and the rate mode are fixed when the block is built. In full-rate mode one bit leaves on every rising serial edge. In half-rate mode the serial clock runs at half that speed, and one bit leaves on each of its two edges.

A factor of one turns the block into a plain buffer, with no clocked path at all. A mode input replaces the core's data with a fixed clock-shaped pattern, so that the lane can act as a forwarded reference clock for a bus whose data lanes use the same factor. The parallel domain applies the output enable and the pattern choice to the whole word before the serial domain sees it. The serial side is therefore a plain shifter.

Top module: `lvds_tx_serializer`

## Requirements
- R1: The factor may be any of 1, 2, 3, 4, 5, 6, 7, 8 or 10. The value 9, any value above 10 and zero are rejected when the block is built. In half-rate mode the factor must also be even and at least 2.
- R2: With a factor of 1, `tx_out` follows `par_oe AND par_data[0]` combinationally, with no clock involved. `ref_mode` has no effect in this case.
- R3: In full-rate mode, a word is captured on a rising edge of `par_clk`. Its bit FACTOR-1 drives `tx_out` after the next rising edge of `ser_clk`. Each later rising serial edge presents the next lower bit. Consecutive words follow one another with no gap and no repeated bit.
- R4: In half-rate mode, from the rising serial edge after capture, the k-th serial period (k counted from 0) carries two bits. Bit FACTOR-1-2k is on `tx_out` while `ser_clk` is high, and bit FACTOR-2-2k is on `tx_out` while `ser_clk` is low.
- R5: When `par_oe` is low at the capture edge and `ref_mode` is low, `tx_out` is 0 for the whole slot of that word.
- R6: When `ref_mode` is high at the capture edge, the word sent is a clock pattern. The top ceil(FACTOR/2) bits are 1 and the rest are 0, sent MSB first (factor 7 gives 1111000, factor 8 gives 11110000).
- R7: In reference-clock mode, `par_oe` and `par_data` have no effect on the transmitted pattern.
- R8: Reset is synchronous and active low. A serial edge that sees `rst_n` low clears the shifter, so `tx_out` is 0 after that edge. In half-rate mode this also holds in the following low phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ser_clk | input | 1 | Fast serial clock, phase-locked to `par_clk` |
| par_clk | input | 1 | Slow parallel clock; its rising edge captures the core word |
| rst_n | input | 1 | Synchronous active-low reset, used in both clock domains |
| par_data | input | FACTOR | Parallel word from the core; bit FACTOR-1 is sent first |
| par_oe | input | 1 | Output enable for data mode, sampled with the word |
| ref_mode | input | 1 | Selects the reference-clock pattern in place of data |
| tx_out | output | 1 | Serial bit toward the lane driver |

## Verification
Several properties are checked on every cycle. The parallel-domain properties check that a disabled word becomes all zeros and that reference mode yields the fixed pattern. On the serial side, a counter confirms that word loads arrive exactly once per parallel period, and each load must place the word's leading bit (or leading bit pair, in half-rate mode) on the output path on the next serial edge. The build-time check rejects an illegal factor. Only the bench scenarios can show the rest: the complete bit order over a whole word in both rate modes, the low-phase bits of the half-rate output, the combinational buffer at factor 1, and the output clearing when reset arrives in the middle of a word.

// File: rtl/lvds_ser_pkg.sv
// Shared constants and helper functions for the lane serializer.
// Assumes factors never exceed MAX_FACTOR.
package lvds_ser_pkg;

    localparam int MAX_FACTOR = 10;

    // True when the factor / rate combination can be built.
    function automatic bit factor_legal(int factor, bit half_rate);
        bit ok;
        ok = ((factor >= 1) && (factor <= 8)) || (factor == 10);
        if (half_rate) begin
            ok = ok && (factor >= 2) && ((factor % 2) == 0);
        end
        return ok;
    endfunction

    // Clock-shaped word: upper ceil(factor/2) bits set, the rest clear.
    function automatic logic [MAX_FACTOR-1:0] ref_pattern(int factor);
        logic [MAX_FACTOR-1:0] pat;
        int                    hi_bits;
        pat     = '0;
        hi_bits = (factor + 1) / 2;
        for (int i = 0; i < MAX_FACTOR; i++) begin
            if ((i < factor) && (i >= factor - hi_bits)) begin
                pat[i] = 1'b1;
            end
        end
        return pat;
    endfunction

endpackage

// File: rtl/ser_word_capture.sv
// Parallel-domain front end. On each parallel edge it registers the word to
// be sent: the reference pattern, the core data, or all zeros when the
// output is disabled. It flips a toggle so that the serial domain sees a
// fresh word. Assumes par_clk is phase-locked to the serial clock.
module ser_word_capture #(
    parameter int W = 10
) (
    input  logic         par_clk,
    input  logic         rst_n,
    input  logic [W-1:0] par_data,
    input  logic         par_oe,
    input  logic         ref_mode,
    output logic [W-1:0] word_q,
    output logic         tog_q
);

    localparam logic [W-1:0] PATTERN = W'(lvds_ser_pkg::ref_pattern(W));

    // Register the gated word and announce it with a toggle.
    always_ff @(posedge par_clk) begin
        if (!rst_n) begin
            word_q <= '0;
            tog_q  <= 1'b0;
        end else begin
            tog_q <= ~tog_q;
            if (ref_mode) begin
                word_q <= PATTERN;
            end else if (par_oe) begin
                word_q <= par_data;
            end else begin
                word_q <= '0;
            end
        end
    end

    AST_DISABLED_WORD_ZERO: assert property (@(posedge par_clk) disable iff (!rst_n)
        (!par_oe && !ref_mode) |=> (word_q == '0)); // R5

    AST_REF_IGNORES_DATA: assert property (@(posedge par_clk) disable iff (!rst_n)
        ref_mode |=> (word_q == PATTERN)); // R7

endmodule

// File: rtl/ser_load_detect.sv
// Serial-domain load strobe. It compares the parallel toggle with the copy
// last seen and raises load for one serial edge per parallel period.
// Assumes both clocks come from one source, so no synchronizer is needed.
module ser_load_detect #(
    parameter int STEPS = 10
) (
    input  logic ser_clk,
    input  logic rst_n,
    input  logic tog_in,
    output logic load
);

    localparam int CW = $clog2(STEPS + 1);

    logic          tog_seen_q;
    logic [CW-1:0] gap_q;
    logic          seen_q;

    assign load = tog_in ^ tog_seen_q;

    // Track the toggle value already consumed.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            tog_seen_q <= 1'b0;
        end else begin
            tog_seen_q <= tog_in;
        end
    end

    // Checker counter: serial edges since the last load (saturating).
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (load) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != CW'(STEPS)) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_LOAD_CADENCE: assert property (@(posedge ser_clk) disable iff (!rst_n)
        (load && seen_q) |-> (gap_q == CW'(STEPS - 1))); // R3

endmodule

// File: rtl/ser_shift_reg.sv
// Word shifter. It loads the captured word on a load strobe and otherwise
// moves it up by STEP bits per rising serial edge. It exposes the top STEP
// bits as the bits currently leaving. Assumes W >= STEP.
module ser_shift_reg #(
    parameter int W    = 10,
    parameter int STEP = 1
) (
    input  logic            ser_clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [W-1:0]    word,
    output logic [STEP-1:0] head_o
);

    logic [W-1:0] sreg_q;

    // Load a new word or advance the current one.
    always_ff @(posedge ser_clk) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (load) begin
            sreg_q <= word;
        end else begin
            sreg_q <= sreg_q << STEP;
        end
    end

    assign head_o = sreg_q[W-1 -: STEP];

endmodule

// File: rtl/ser_ddr_out.sv
// Double-edge output stage. The rising-edge bit drives the pin while the
// serial clock is high. The second bit is retimed on the falling edge and
// drives the pin while the clock is low. Assumes both bits change only on
// rising edges.
module ser_ddr_out (
    input  logic ser_clk,
    input  logic rst_n,
    input  logic rise_bit,
    input  logic fall_bit,
    output logic tx_out
);

    logic fall_q;

    // Retime the low-phase bit so it cannot glitch during the high phase.
    always_ff @(negedge ser_clk) begin
        if (!rst_n) begin
            fall_q <= 1'b0;
        end else begin
            fall_q <= fall_bit;
        end
    end

    assign tx_out = ser_clk ? rise_bit : fall_q;

endmodule

// File: rtl/lvds_tx_serializer.sv
// Top of the transmit lane serializer. A factor of 1 builds a plain
// combinational buffer. Otherwise it builds the capture, load-detect and
// shift stages, plus a double-edge output stage in half-rate mode.
// Assumes ser_clk runs FACTOR (full rate) or FACTOR/2 (half rate) times
// faster than par_clk and is phase-locked to it.
module lvds_tx_serializer #(
    parameter int FACTOR    = 10,
    parameter bit HALF_RATE = 1'b0
) (
    input  logic              ser_clk,
    input  logic              par_clk,
    input  logic              rst_n,
    input  logic [FACTOR-1:0] par_data,
    input  logic              par_oe,
    input  logic              ref_mode,
    output logic              tx_out
);

    localparam int STEP  = HALF_RATE ? 2 : 1;
    localparam int STEPS = FACTOR / STEP;

    initial begin
        AST_LEGAL_FACTOR: assert (lvds_ser_pkg::factor_legal(FACTOR, HALF_RATE)) // R1
            else $error("serializer: illegal factor %0d for this rate mode", FACTOR);
    end

    if (FACTOR == 1) begin : g_bypass
        assign tx_out = par_oe & par_data[0];
    end else begin : g_ser
        logic [FACTOR-1:0] word;
        logic              tog;
        logic              load;
        logic [STEP-1:0]   head;

        ser_word_capture #(.W(FACTOR)) u_capture (
            .par_clk  (par_clk),
            .rst_n    (rst_n),
            .par_data (par_data),
            .par_oe   (par_oe),
            .ref_mode (ref_mode),
            .word_q   (word),
            .tog_q    (tog)
        );

        ser_load_detect #(.STEPS(STEPS)) u_detect (
            .ser_clk (ser_clk),
            .rst_n   (rst_n),
            .tog_in  (tog),
            .load    (load)
        );

        ser_shift_reg #(.W(FACTOR), .STEP(STEP)) u_shift (
            .ser_clk (ser_clk),
            .rst_n   (rst_n),
            .load    (load),
            .word    (word),
            .head_o  (head)
        );

        if (HALF_RATE) begin : g_half
            ser_ddr_out u_ddr (
                .ser_clk  (ser_clk),
                .rst_n    (rst_n),
                .rise_bit (head[1]),
                .fall_bit (head[0]),
                .tx_out   (tx_out)
            );

            AST_PAIR_ON_LOAD: assert property (@(posedge ser_clk) disable iff (!rst_n)
                load |=> (head == $past(word[FACTOR-1 -: 2]))); // R4
        end else begin : g_full
            assign tx_out = head[0];

            AST_MSB_FIRST: assert property (@(posedge ser_clk) disable iff (!rst_n)
                load |=> (tx_out == $past(word[FACTOR-1]))); // R3
        end
    end

endmodule

// File: tb/lvds_tx_serializer_tb.sv
`timescale 1ns/1ps
module lvds_tx_serializer_tb;

    logic ser_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic p7 = 1'b0, p4 = 1'b0;
    int   c7 = 0, c4 = 0;

    logic [6:0] d7 = '0; logic oe7 = 1'b0, ref7 = 1'b0; logic tx7;
    logic [7:0] d8 = '0; logic oe8 = 1'b0, ref8 = 1'b0; logic tx8;
    logic [0:0] d1 = '0; logic oe1 = 1'b0, ref1 = 1'b0; logic tx1;

    int checks = 0;
    int errors = 0;

    // 125 MHz serial clock
    initial forever #4 ser_clk = ~ser_clk;

    // Phase-locked parallel clocks: /7 for the full-rate lane, /4 for half-rate 8
    always @(posedge ser_clk) begin
        c7 <= (c7 == 6) ? 0 : c7 + 1;
        p7 <= (((c7 == 6) ? 0 : c7 + 1) < 4);
        c4 <= (c4 == 3) ? 0 : c4 + 1;
        p4 <= (((c4 == 3) ? 0 : c4 + 1) < 2);
    end

    lvds_tx_serializer #(.FACTOR(7), .HALF_RATE(1'b0)) u_dut (
        .ser_clk(ser_clk), .par_clk(p7), .rst_n(rst_n),
        .par_data(d7), .par_oe(oe7), .ref_mode(ref7), .tx_out(tx7));

    lvds_tx_serializer #(.FACTOR(8), .HALF_RATE(1'b1)) u_hr (
        .ser_clk(ser_clk), .par_clk(p4), .rst_n(rst_n),
        .par_data(d8), .par_oe(oe8), .ref_mode(ref8), .tx_out(tx8));

    lvds_tx_serializer #(.FACTOR(1), .HALF_RATE(1'b0)) u_buf (
        .ser_clk(ser_clk), .par_clk(p7), .rst_n(rst_n),
        .par_data(d1), .par_oe(oe1), .ref_mode(ref1), .tx_out(tx1));

    // {data[6:0], oe, ref, expected serial word[6:0]} for the factor-7 lane
    localparam logic [15:0] VEC [8] = '{
        {7'b1011001, 1'b1, 1'b0, 7'b1011001},
        {7'b0000001, 1'b1, 1'b0, 7'b0000001},
        {7'b1111111, 1'b1, 1'b0, 7'b1111111},
        {7'b1010101, 1'b0, 1'b0, 7'b0000000},
        {7'b0110110, 1'b0, 1'b1, 7'b1111000},
        {7'b0000000, 1'b1, 1'b1, 7'b1111000},
        {7'b1100011, 1'b1, 1'b0, 7'b1100011},
        {7'b1000000, 1'b1, 1'b0, 7'b1000000}
    };

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Wait for the capture edge, then sample 7 bits on successive rising edges.
    task automatic collect7(output logic [6:0] w);
        @(posedge p7);
        for (int k = 0; k < 7; k++) begin
            @(posedge ser_clk); #2;
            w[6-k] = tx7;
        end
    endtask

    // Wait for the capture edge, then sample high and low phase of 4 periods.
    task automatic collect8(output logic [7:0] w);
        @(posedge p4);
        for (int j = 0; j < 4; j++) begin
            @(posedge ser_clk); #2;
            w[7-2*j] = tx8;
            @(negedge ser_clk); #2;
            w[6-2*j] = tx8;
        end
    endtask

    task automatic run8(string req, logic [7:0] d, logic oe, logic rf, logic [7:0] exp);
        logic [7:0] got;
        d8 = d; oe8 = oe; ref8 = rf;
        collect8(got);
        check(req, {8'h00, got}, {8'h00, exp});
    endtask

    initial begin
        logic [6:0] got7;
        logic [6:0] exp7;
        string      tag;

        // R1: build-time legality of factor / rate combinations
        for (int f = 0; f <= 12; f++) begin
            bit ef, eh;
            ef = (f != 0) && (f != 9) && (f <= 10);
            eh = ef && (f == 2 || f == 4 || f == 6 || f == 8 || f == 10);
            check("R1", {14'd0, lvds_ser_pkg::factor_legal(f, 1'b0),
                   lvds_ser_pkg::factor_legal(f, 1'b1)}, {14'd0, ef, eh});
        end

        // R8: outputs are low while held in reset
        repeat (20) @(posedge ser_clk);
        #2;
        check("R8", {15'd0, tx7}, 16'd0);
        check("R8", {15'd0, tx8}, 16'd0);
        @(negedge ser_clk);
        rst_n = 1'b1;

        // R3 R5 R6 R7: vector table on the full-rate factor-7 lane
        for (int i = 0; i < 8; i++) begin
            d7   = VEC[i][15:9];
            oe7  = VEC[i][8];
            ref7 = VEC[i][7];
            exp7 = VEC[i][6:0];
            tag  = ref7 ? "R6 R7" : (oe7 ? "R3" : "R5");
            collect7(got7);
            check(tag, {9'd0, got7}, {9'd0, exp7});
        end

        // R4 R5 R6 R7: half-rate factor-8 lane
        run8("R4", 8'b10110010, 1'b1, 1'b0, 8'b10110010);
        run8("R4", 8'b01000011, 1'b1, 1'b0, 8'b01000011);
        run8("R5", 8'b11111111, 1'b0, 1'b0, 8'b00000000);
        run8("R6 R7", 8'b00110101, 1'b0, 1'b1, 8'b11110000);

        // R2: factor-1 buffer is combinational and ignores reference mode
        d1 = 1'b1; oe1 = 1'b1; #1;
        check("R2", {15'd0, tx1}, 16'd1);
        oe1 = 1'b0; #1;
        check("R2", {15'd0, tx1}, 16'd0);
        d1 = 1'b0; oe1 = 1'b1; #1;
        check("R2", {15'd0, tx1}, 16'd0);
        d1 = 1'b1; ref1 = 1'b1; #1;
        check("R2", {15'd0, tx1}, 16'd1);

        // R8: reset in the middle of an all-ones stream clears the output
        d7 = 7'h7f; oe7 = 1'b1; ref7 = 1'b0;
        d8 = 8'hff; oe8 = 1'b1; ref8 = 1'b0;
        repeat (20) @(posedge ser_clk);
        @(negedge ser_clk);
        rst_n = 1'b0;
        @(posedge ser_clk); #2;
        check("R8", {15'd0, tx7}, 16'd0);
        check("R8", {15'd0, tx8}, 16'd0);
        @(negedge ser_clk); #2;
        check("R8", {15'd0, tx8}, 16'd0);
        repeat (20) @(negedge ser_clk);
        rst_n = 1'b1;

        // R3: stream resumes correctly after reset
        d7 = 7'b0101100; oe7 = 1'b1;
        collect7(got7);
        check("R3", {9'd0, got7}, {9'd0, 7'b0101100});

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #1600000;
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule